// File: doc/BRIEF.md
# Four-Lane Frame Merger with Type Tagging

The block collects 64-bit frames that arrive on four parallel lanes in lockstep. On one write-clock cycle all four lanes present a frame together with a 2-bit sync field. The sync field says whether the frame carries hit data or a register readback. Frames with any other sync value are discarded and counted. Each good frame is tagged with its type. The whole aligned set then crosses into an unrelated read clock through a dual-clock FIFO that uses Gray-coded pointers and two-flop synchronizers.

On the read side, a sequencer unpacks each set in ascending lane order and presents one frame per cycle on a valid/ready output. The sequencer also marks packet boundaries for a downstream link core. A packet starts after the previous one has ended. A packet ends when the frame type changes, or when no further frame is waiting at the moment a frame is placed on the output. If the FIFO has no room, the whole aligned set is dropped and a sticky overflow flag is raised.

Top module: `lane_merge_tagger`

## Requirements
- R1: Good frames leave in the order their sets arrived, and within a set in ascending lane index (lane 0 first). The payload is unchanged. Lane i occupies `in_payload[64*i +: 64]` and `in_sync[2*i +: 2]`.
- R2: Sync value 2'b01 marks a hit-data frame and produces `out_tag` = 0. Sync value 2'b10 marks a register frame and produces `out_tag` = 1.
- R3: A lane whose sync is 2'b00 or 2'b11 produces no output word. `err_count` rises by the number of such lanes in each presented set, and it saturates at its maximum value.
- R4: While the output is stalled, the block holds at most 2^FIFO_AW + 1 sets. A set presented when the FIFO is full is dropped completely. A drop sets `overflow`, which stays at 1 until reset.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle keeps `out_valid` at 1 and keeps `out_data`, `out_tag` and `out_eop` unchanged.
- R6: `out_sop` is 1 exactly on the first word after reset and on every word that follows a word with `out_eop` = 1.
- R7: `out_eop` is 1 on a word if the next waiting word has a different tag, or if no word is waiting when this word is placed on the output. A word without `out_eop` is always followed by a word with the same tag.
- R8: After reset, `out_valid`, `err_count` and `overflow` are all 0.
- R9: A set in which no lane has a good sync produces no output word and never sets `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Lane-side clock |
| wr_rst_n | input | 1 | Active-low reset, lane side |
| in_set_valid | input | 1 | All lanes present a frame this cycle |
| in_sync | input | 2*LANES | Per-lane sync/type field |
| in_payload | input | 64*LANES | Per-lane frame payload |
| err_count | output | ERR_W | Saturating count of bad-sync frames |
| overflow | output | 1 | Sticky: a set was dropped for lack of room |
| rd_clk | input | 1 | Output-side clock |
| rd_rst_n | input | 1 | Active-low reset, output side |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Word present |
| out_data | output | 64 | Frame payload |
| out_tag | output | 1 | 0 = hit data, 1 = register frame |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |

## Verification
In one read cycle, the last remaining lane of the held set can move to the output while the next set is popped from the FIFO. The end-of-packet decision for that lane then depends on the set that arrives in that same cycle. To provoke this, the bench stalls the output while several sets of mixed types fill the FIFO, then releases `out_ready` so the sets drain back to back. During this drain, the bench requires `out_eop` exactly where the tag changes and on the final word. It also checks stalled-output stability and whole-set drops against a model of what the block can hold.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
    localparam logic [1:0] SYNC_HIT = 2'b01;
    localparam logic [1:0] SYNC_REG = 2'b10;
    localparam logic       TAG_HIT  = 1'b0;
    localparam logic       TAG_REG  = 1'b1;
endpackage

// File: rtl/lmt_sync2.sv
module lmt_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.s2;
endmodule

// File: rtl/lmt_async_fifo.sv
module lmt_async_fifo #(
    parameter int W  = 8,
    parameter int AW = 3
) (
    input  logic         wr_clk,
    input  logic         wr_rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    input  logic         rd_clk,
    input  logic         rd_rst_n,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
    } ptr_t;

    ptr_t        w_d, w_q, r_d, r_q;
    logic [AW:0] rgray_s, wgray_s;
    logic [W-1:0] mem [DEPTH];

    // write side: full when the Gray pointers differ only in the two top bits
    always_comb begin
        w_d  = w_q;
        full = (w_q.gray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
        if (wr_en && !full) begin
            w_d.bin  = w_q.bin + 1'b1;
            w_d.gray = w_d.bin ^ (w_d.bin >> 1);
        end
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) w_q <= '0;
        else           w_q <= w_d;
    end

    always_ff @(posedge wr_clk) begin
        if (wr_en && !full) mem[w_q.bin[AW-1:0]] <= wr_data;
    end

    // read side: head entry is visible without a pop
    always_comb begin
        r_d   = r_q;
        empty = (r_q.gray == wgray_s);
        if (rd_en && !empty) begin
            r_d.bin  = r_q.bin + 1'b1;
            r_d.gray = r_d.bin ^ (r_d.bin >> 1);
        end
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) r_q <= '0;
        else           r_q <= r_d;
    end

    assign rd_data = mem[r_q.bin[AW-1:0]];

    lmt_sync2 #(.W(AW + 1)) u_wptr_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_q.gray),
        .q     (wgray_s)
    );

    lmt_sync2 #(.W(AW + 1)) u_rptr_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (r_q.gray),
        .q     (rgray_s)
    );
endmodule

// File: rtl/lmt_lane_tagger.sv
module lmt_lane_tagger
    import lmt_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PAY_W = 64,
    parameter int ERR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_valid,
    input  logic [2*LANES-1:0]       lane_sync,
    input  logic [LANES*PAY_W-1:0]   lane_data,
    input  logic                     fifo_full,
    output logic                     wr_en,
    output logic [LANES*(PAY_W+2)-1:0] wr_entry,
    output logic [ERR_W-1:0]         err_count,
    output logic                     overflow
);
    localparam int LW    = PAY_W + 2;
    localparam int CNT_W = $clog2(LANES + 1);

    typedef struct packed {
        logic [ERR_W-1:0] err;
        logic             ovf;
    } wstate_t;

    wstate_t          s_d, s_q;
    logic [CNT_W-1:0] bad;
    logic             any_good;
    logic [ERR_W:0]   err_sum;

    always_comb begin
        bad      = '0;
        any_good = 1'b0;
        wr_entry = '0;
        for (int i = 0; i < LANES; i++) begin
            wr_entry[i*LW +: PAY_W] = lane_data[i*PAY_W +: PAY_W];
            wr_entry[i*LW + PAY_W]  = (lane_sync[2*i +: 2] == SYNC_REG) ? TAG_REG : TAG_HIT;
            if (lane_sync[2*i +: 2] == SYNC_HIT || lane_sync[2*i +: 2] == SYNC_REG) begin
                wr_entry[i*LW + PAY_W + 1] = 1'b1;
                any_good = 1'b1;
            end else begin
                bad = bad + CNT_W'(1);
            end
        end

        err_sum = {1'b0, s_q.err} + (ERR_W + 1)'(bad);
        s_d     = s_q;
        wr_en   = set_valid && any_good && !fifo_full;
        if (set_valid) begin
            s_d.err = err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];
            if (any_good && fifo_full) s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign err_count = s_q.err;
    assign overflow  = s_q.ovf;
endmodule

// File: rtl/lmt_merge_reader.sv
module lmt_merge_reader #(
    parameter int LANES = 4,
    parameter int PAY_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES*(PAY_W+2)-1:0] head,
    input  logic                       empty,
    output logic                       pop,
    input  logic                       out_ready,
    output logic                       out_valid,
    output logic [PAY_W-1:0]           out_data,
    output logic                       out_tag,
    output logic                       out_sop,
    output logic                       out_eop
);
    localparam int LW    = PAY_W + 2;
    localparam int ENT_W = LANES * LW;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic [ENT_W-1:0] entry;
        logic [LANES-1:0] rem;
        logic             ov;
        logic [PAY_W-1:0] data;
        logic             tag;
        logic             sop;
        logic             eop;
        logic             prev_eop;
    } rstate_t;

    rstate_t          s_d, s_q;
    logic [LANES-1:0] head_mask, rem_after;
    logic [IDX_W-1:0] pick;
    logic             pick_tag, next_tag, has_next, slot_free, take;

    function automatic logic [IDX_W-1:0] low_idx(input logic [LANES-1:0] m);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (m[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    always_comb begin
        for (int i = 0; i < LANES; i++) head_mask[i] = head[i*LW + PAY_W + 1];

        slot_free = !s_q.ov || out_ready;
        take      = slot_free && (s_q.rem != '0);
        pick      = low_idx(s_q.rem);
        pick_tag  = s_q.entry[pick*LW + PAY_W];
        rem_after = s_q.rem;
        if (take) rem_after[pick] = 1'b0;
        pop = !empty && (rem_after == '0);

        // what follows the word being placed: rest of this set, else FIFO head
        if (rem_after != '0) begin
            has_next = 1'b1;
            next_tag = s_q.entry[low_idx(rem_after)*LW + PAY_W];
        end else if (!empty) begin
            has_next = 1'b1;
            next_tag = head[low_idx(head_mask)*LW + PAY_W];
        end else begin
            has_next = 1'b0;
            next_tag = 1'b0;
        end

        s_d = s_q;
        if (s_q.ov && out_ready) begin
            s_d.ov       = 1'b0;
            s_d.prev_eop = s_q.eop;
        end
        if (take) begin
            s_d.ov   = 1'b1;
            s_d.data = s_q.entry[pick*LW +: PAY_W];
            s_d.tag  = pick_tag;
            s_d.sop  = s_q.ov ? s_q.eop : s_q.prev_eop;
            s_d.eop  = !has_next || (next_tag != pick_tag);
        end
        s_d.rem = rem_after;
        if (pop) begin
            s_d.entry = head;
            s_d.rem   = head_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.prev_eop <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.ov;
    assign out_data  = s_q.data;
    assign out_tag   = s_q.tag;
    assign out_sop   = s_q.sop;
    assign out_eop   = s_q.eop;
endmodule

// File: rtl/lane_merge_tagger.sv
module lane_merge_tagger #(
    parameter int LANES   = 4,
    parameter int PAY_W   = 64,
    parameter int FIFO_AW = 3,
    parameter int ERR_W   = 16
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst_n,
    input  logic                     in_set_valid,
    input  logic [2*LANES-1:0]       in_sync,
    input  logic [LANES*PAY_W-1:0]   in_payload,
    output logic [ERR_W-1:0]         err_count,
    output logic                     overflow,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [PAY_W-1:0]         out_data,
    output logic                     out_tag,
    output logic                     out_sop,
    output logic                     out_eop
);
    localparam int ENT_W = LANES * (PAY_W + 2);

    logic             fifo_full, fifo_empty, fifo_wr, fifo_pop;
    logic [ENT_W-1:0] wr_entry, head;

    lmt_lane_tagger #(.LANES(LANES), .PAY_W(PAY_W), .ERR_W(ERR_W)) u_tagger (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .set_valid (in_set_valid),
        .lane_sync (in_sync),
        .lane_data (in_payload),
        .fifo_full (fifo_full),
        .wr_en     (fifo_wr),
        .wr_entry  (wr_entry),
        .err_count (err_count),
        .overflow  (overflow)
    );

    lmt_async_fifo #(.W(ENT_W), .AW(FIFO_AW)) u_fifo (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_en    (fifo_wr),
        .wr_data  (wr_entry),
        .full     (fifo_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (fifo_pop),
        .rd_data  (head),
        .empty    (fifo_empty)
    );

    lmt_merge_reader #(.LANES(LANES), .PAY_W(PAY_W)) u_reader (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .head      (head),
        .empty     (fifo_empty),
        .pop       (fifo_pop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_tag   (out_tag),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );
endmodule

// File: rtl/lmt_checker.sv
module lmt_checker #(
    parameter int PAY_W = 64,
    parameter int ERR_W = 16
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic [ERR_W-1:0] err_count,
    input logic             overflow,
    input logic             out_ready,
    input logic             out_valid,
    input logic [PAY_W-1:0] out_data,
    input logic             out_tag,
    input logic             out_sop,
    input logic             out_eop
);
    logic last_eop_c, last_tag_c;

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            last_eop_c <= 1'b1;
            last_tag_c <= 1'b0;
        end else if (out_valid && out_ready) begin
            last_eop_c <= out_eop;
            last_tag_c <= out_tag;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag) && $stable(out_eop));

    // R6
    sop_after_eop_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_valid |-> out_sop == last_eop_c);

    // R7
    same_type_run_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        out_valid && !last_eop_c |-> out_tag == last_tag_c);

    // R4
    ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        overflow |=> overflow);

    // R3
    err_mono_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_rst_n |=> err_count >= $past(err_count));
endmodule

bind lane_merge_tagger lmt_checker #(.PAY_W(PAY_W), .ERR_W(ERR_W)) u_lmt_checker (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .err_count (err_count),
    .overflow  (overflow),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_tag   (out_tag),
    .out_sop   (out_sop),
    .out_eop   (out_eop)
);

// File: tb/lane_merge_tagger_bench.sv
module lane_merge_tagger_bench;
    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic          in_set_valid = 1'b0;
    logic [7:0]    in_sync = '0;
    logic [255:0]  in_payload = '0;
    logic [15:0]   err_count;
    logic          overflow;
    logic          out_ready = 1'b0;
    logic          out_valid, out_tag, out_sop, out_eop;
    logic [63:0]   out_data;

    int total = 0, bad = 0, got = 0, exp_err = 0, burst_cnt = 0;
    bit done = 0, burst_mode = 0, stall_on = 0;
    logic [64:0] exp_q[$];
    logic [64:0] e;
    bit   prev_stall = 0, have_last = 0;
    logic last_eop = 1'b1, last_tag = 1'b0, p_tag = 1'b0, p_eop = 1'b0;
    logic [63:0] p_data = '0;

    always #10 wr_clk = ~wr_clk;
    always #7  rd_clk = ~rd_clk;

    lane_merge_tagger u_lane_merge_tagger (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_set_valid(in_set_valid),
        .in_sync(in_sync), .in_payload(in_payload), .err_count(err_count),
        .overflow(overflow), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_tag(out_tag), .out_sop(out_sop), .out_eop(out_eop)
    );

    task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rand_good();
        logic [7:0] s;
        for (int i = 0; i < 4; i++) s[2*i +: 2] = ($urandom % 2) ? 2'b10 : 2'b01;
        return s;
    endfunction

    // driver: presents one aligned set, records expected frames in lane order
    task automatic push_set(input logic [7:0] sy, input bit keep, input int gap);
        logic [255:0] pl;
        for (int i = 0; i < 4; i++) pl[i*64 +: 64] = {$urandom, $urandom};
        @(negedge wr_clk);
        in_set_valid = 1'b1;
        in_sync      = sy;
        in_payload   = pl;
        for (int i = 0; i < 4; i++) begin
            if (sy[2*i +: 2] == 2'b01 || sy[2*i +: 2] == 2'b10) begin
                if (keep) exp_q.push_back({sy[2*i +: 2] == 2'b10, pl[i*64 +: 64]});
            end else begin
                exp_err++;
            end
        end
        @(negedge wr_clk);
        in_set_valid = 1'b0;
        repeat (gap) @(negedge wr_clk);
    endtask

    task automatic set_ready(input logic v);
        @(posedge rd_clk);
        #2 out_ready = v;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge rd_clk);
        repeat (10) @(negedge rd_clk);
    endtask

    // monitor: compares every accepted word against the queue
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (prev_stall)
                chk(out_valid && out_data == p_data && out_tag == p_tag && out_eop == p_eop,
                    "R5", {out_tag, out_data}, {p_tag, p_data});
            prev_stall = out_valid && !out_ready;
            p_data = out_data; p_tag = out_tag; p_eop = out_eop;
            if (out_valid && out_ready) begin
                got++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected word", {out_tag, out_data}, '0);
                end else begin
                    e = exp_q.pop_front();
                    chk(out_data == e[63:0], "R1", {1'b0, out_data}, {1'b0, e[63:0]});
                    chk(out_tag == e[64], "R2", {64'd0, out_tag}, {64'd0, e[64]});
                end
                chk(out_sop == last_eop, "R6", {64'd0, out_sop}, {64'd0, last_eop});
                if (have_last && !last_eop)
                    chk(out_tag == last_tag, "R7", {64'd0, out_tag}, {64'd0, last_tag});
                if (burst_mode && burst_cnt > 0 && last_eop)
                    chk(out_tag != last_tag, "R7 strict", {64'd0, out_tag}, {64'd0, ~last_tag});
                if (burst_mode) burst_cnt++;
                last_eop = out_eop; last_tag = out_tag; have_last = 1;
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int g0;
        repeat (5) @(negedge wr_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        // R8
        chk(out_valid == 1'b0, "R8", {64'd0, out_valid}, '0);
        chk(err_count == 16'd0, "R8", {49'd0, err_count}, '0);
        chk(overflow == 1'b0, "R8", {64'd0, overflow}, '0);

        // R1 R2: random good sets at a rate the output keeps up with
        set_ready(1'b1);
        repeat (30) push_set(rand_good(), 1'b1, 5);
        drain();
        chk(exp_q.size() == 0, "R1", 65'(exp_q.size()), '0);

        // R3: bad sync values on chosen lanes
        push_set(8'b00_01_11_10, 1'b1, 5);
        push_set(8'b10_11_01_00, 1'b1, 5);
        push_set(8'b01_01_01_11, 1'b1, 5);
        drain();
        @(negedge wr_clk);
        chk(err_count == 16'(exp_err), "R3", {49'd0, err_count}, 65'(exp_err));

        // R9: set with no good lane
        g0 = got;
        push_set(8'b11_00_11_00, 1'b1, 5);
        repeat (30) @(negedge rd_clk);
        chk(got == g0, "R9", 65'(got), 65'(g0));
        chk(overflow == 1'b0, "R9", {64'd0, overflow}, '0);
        chk(err_count == 16'(exp_err), "R3", {49'd0, err_count}, 65'(exp_err));

        // R5: random back-pressure while sets arrive
        stall_on = 1;
        fork
            begin
                repeat (25) push_set(rand_good(), 1'b1, 12);
                stall_on = 0;
            end
            begin
                while (stall_on) set_ready(1'($urandom % 2));
            end
        join
        set_ready(1'b1);
        drain();
        chk(exp_q.size() == 0, "R5", 65'(exp_q.size()), '0);

        // R7: fill while stalled, then drain back to back
        set_ready(1'b0);
        push_set(8'b01_01_01_01, 1'b1, 6);
        push_set(8'b10_10_01_01, 1'b1, 6);
        push_set(8'b10_10_10_10, 1'b1, 6);
        push_set(8'b01_10_10_01, 1'b1, 6);
        push_set(8'b01_01_01_10, 1'b1, 6);
        repeat (20) @(negedge rd_clk);
        burst_mode = 1;
        burst_cnt  = 0;
        set_ready(1'b1);
        drain();
        chk(last_eop == 1'b1, "R7 final", {64'd0, last_eop}, 65'd1);
        burst_mode = 0;

        // R4: overflow drops whole sets beyond 2^3 + 1 while stalled
        chk(overflow == 1'b0, "R4", {64'd0, overflow}, '0);
        set_ready(1'b0);
        for (int k = 0; k < 12; k++) push_set(rand_good(), k < 9, 6);
        repeat (4) @(negedge wr_clk);
        chk(overflow == 1'b1, "R4", {64'd0, overflow}, 65'd1);
        set_ready(1'b1);
        drain();
        chk(exp_q.size() == 0, "R4", 65'(exp_q.size()), '0);
        push_set(rand_good(), 1'b1, 6);
        drain();
        chk(overflow == 1'b1, "R4 sticky", {64'd0, overflow}, 65'd1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule